// File: doc/BRIEF.md
# Four-Port Registered Bus Exchanger

This block routes 9-bit data between four ports, called 1A, 2A, 1B and 2B. Each port has an input bus, an output bus driven from its own data register, and an output-enable flag. A 5-bit select code picks a routing state that joins the ports in pairs and gives each pair zero or one one-way path. At most two paths are active at once.

The block works in two phases, chosen by a single select-enable input. With select-enable low, a rising clock edge captures the select code into a routing register. The new output enables apply from that same edge. With select-enable high, a rising clock edge copies each active path's source input into its destination's data register, and the routing state is held.

An asynchronous preset clears the routing state, so every output enable drops at once, with no clock edge needed. An active-low reset applies the same clear and also zeroes every data register. Output enables are plain logic flags. Driving real tri-state pads from them is left to the surrounding logic.

Top module: `bus_exchanger`

## Requirements
- R1: At a rising edge with select-enable low and preset low, the routing register loads the select code and the enables follow from that edge. No data register changes on such an edge.
- R2: At a rising edge with select-enable high and preset low, each destination of an active path loads its source port's input. The routing state and the enables stay unchanged.
- R3: While preset is high, every output enable is 0 at once, without waiting for a clock edge.
- R4: Once preset has cleared the routing state, the enables stay 0 until an edge where preset and select-enable are both low. Edges with select-enable high, or with preset high, leave them 0.
- R5: Code 0 (00000) and codes 1 to 7 (00001 to 00111) activate no path. All enables stay 0, and data edges change no register.
- R6: Ports are indexed 0=1A, 1=2A, 2=1B, 3=2B, and portIn, portOut and portOe use that index. Upper bits 01 pair 1A/2A and 1B/2B, and the lower three bits give these paths: 100: 1A->2A and 1B->2B; 101: 1A->2A; 110: 1B->2B; 111: 1A->2A and 2B->1B; 000: 2A->1A and 1B->2B; 001: 2A->1A; 010: 2B->1B; 011: 2A->1A and 2B->1B.
- R7: Upper bits 10 pair 1A/1B and 2A/2B, and the lower three bits give these paths: 001: 1A->1B; 010: 2A->2B; 011: 1A->1B and 2A->2B; 000: 1A->1B and 2B->2A; 101: 1B->1A; 110: 2B->2A; 111: 1B->1A and 2B->2A; 100: 1B->1A and 2A->2B.
- R8: Upper bits 11 pair 1A/2B and 1B/2A, and the lower three bits give these paths: 101: 1A->2B; 110: 2A->1B; 111: 1A->2B and 2A->1B; 100: 1A->2B and 1B->2A; 001: 1B->2A; 010: 2B->1A; 011: 2B->1A and 1B->2A; 000: 2B->1A and 2A->1B.
- R9: A port's enable is 1 only if that port is the destination of an active path, so source ports are never enabled and at most two enables are 1. Outputs come from registers: a change on the inputs between edges does not reach the outputs.
- R10: While reset is low, the routing state is 00000, all enables are 0 and all data outputs are 0.
- R11: On a data edge, a port that is not a destination keeps its previous output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| preset | input | 1 | Asynchronous active-high disable; clears the routing state |
| selEn | input | 1 | Low: load the routing state; high: load data |
| selCode | input | 5 | Routing state code |
| portIn | input | 4x9 | Input bus per port, index 0=1A,1=2A,2=1B,3=2B |
| portOut | output | 4x9 | Registered output bus per port |
| portOe | output | 4 | Output enable per port |

## Verification
All 32 select codes are swept. Each code is loaded with select-enable low and then given one data edge, using port input values that are distinct for every port and every code. The enable pattern after each load shows the pairing and the direction of each path. The port-specific data then shows which source actually reached each destination, and that non-destinations kept their values. Separate sequences raise preset in mid-cycle, try data edges and edges with preset still high, and change the inputs between edges, to separate the asynchronous disable, the re-enable rule and the registered output.

// File: rtl/bus_exchanger_pkg.sv
package bus_exchanger_pkg;
  localparam int NPORT = 4;
  localparam int SELW  = 5;
  localparam int IDXW  = $clog2(NPORT);

  typedef struct packed {
    logic [NPORT-1:0]           dstEn;
    logic [NPORT-1:0][IDXW-1:0] srcSel;
  } routeT;

  typedef struct packed {
    logic [NPORT-1:0]           load;
    logic [NPORT-1:0][IDXW-1:0] srcSel;
  } xferStrobeT;

  // path descriptor {valid, source, destination}
  function automatic logic [2*IDXW:0] mkPath(logic [IDXW-1:0] src, logic [IDXW-1:0] dst);
    return {1'b1, src, dst};
  endfunction

  // ports: 0=1A 1=2A 2=1B 3=2B (R6..R8)
  function automatic routeT decodeFlow(logic [SELW-1:0] code);
    logic [2*IDXW:0] pa;
    logic [2*IDXW:0] pb;
    routeT r;
    pa = '0;
    pb = '0;
    case (code)
      5'b01000: begin pa = mkPath(2'd1, 2'd0); pb = mkPath(2'd2, 2'd3); end
      5'b01001: begin pa = mkPath(2'd1, 2'd0); end
      5'b01010: begin pb = mkPath(2'd3, 2'd2); end
      5'b01011: begin pa = mkPath(2'd1, 2'd0); pb = mkPath(2'd3, 2'd2); end
      5'b01100: begin pa = mkPath(2'd0, 2'd1); pb = mkPath(2'd2, 2'd3); end
      5'b01101: begin pa = mkPath(2'd0, 2'd1); end
      5'b01110: begin pb = mkPath(2'd2, 2'd3); end
      5'b01111: begin pa = mkPath(2'd0, 2'd1); pb = mkPath(2'd3, 2'd2); end
      5'b10000: begin pa = mkPath(2'd0, 2'd2); pb = mkPath(2'd3, 2'd1); end
      5'b10001: begin pa = mkPath(2'd0, 2'd2); end
      5'b10010: begin pb = mkPath(2'd1, 2'd3); end
      5'b10011: begin pa = mkPath(2'd0, 2'd2); pb = mkPath(2'd1, 2'd3); end
      5'b10100: begin pa = mkPath(2'd2, 2'd0); pb = mkPath(2'd1, 2'd3); end
      5'b10101: begin pa = mkPath(2'd2, 2'd0); end
      5'b10110: begin pb = mkPath(2'd3, 2'd1); end
      5'b10111: begin pa = mkPath(2'd2, 2'd0); pb = mkPath(2'd3, 2'd1); end
      5'b11000: begin pa = mkPath(2'd3, 2'd0); pb = mkPath(2'd1, 2'd2); end
      5'b11001: begin pb = mkPath(2'd2, 2'd1); end
      5'b11010: begin pa = mkPath(2'd3, 2'd0); end
      5'b11011: begin pa = mkPath(2'd3, 2'd0); pb = mkPath(2'd2, 2'd1); end
      5'b11100: begin pa = mkPath(2'd0, 2'd3); pb = mkPath(2'd2, 2'd1); end
      5'b11101: begin pa = mkPath(2'd0, 2'd3); end
      5'b11110: begin pb = mkPath(2'd1, 2'd2); end
      5'b11111: begin pa = mkPath(2'd0, 2'd3); pb = mkPath(2'd1, 2'd2); end
      default:  begin pa = '0; pb = '0; end // idle and reserved codes (R5)
    endcase
    r = '0;
    if (pa[2*IDXW]) begin
      r.dstEn[pa[IDXW-1:0]]  = 1'b1;
      r.srcSel[pa[IDXW-1:0]] = pa[2*IDXW-1:IDXW];
    end
    if (pb[2*IDXW]) begin
      r.dstEn[pb[IDXW-1:0]]  = 1'b1;
      r.srcSel[pb[IDXW-1:0]] = pb[2*IDXW-1:IDXW];
    end
    return r;
  endfunction
endpackage

// File: rtl/bus_exchanger_flow_ctrl.sv
module bus_exchanger_flow_ctrl
  import bus_exchanger_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             preset,
  input  logic             selEn,
  input  logic [SELW-1:0]  selCode,
  output xferStrobeT       strobe,
  output logic [NPORT-1:0] portOe
);
  logic [SELW-1:0] flowQ;
  routeT           route;

  // routing state: async clear by reset or preset, load only in the select phase
  always_ff @(posedge clk or negedge rstN or posedge preset) begin
    if (!rstN) begin
      flowQ <= '0;
    end else if (preset) begin
      flowQ <= '0;
    end else if (!selEn) begin
      flowQ <= selCode;
    end
  end

  always_comb begin
    route         = decodeFlow(flowQ);
    strobe.load   = route.dstEn & {NPORT{selEn & ~preset}};
    strobe.srcSel = route.srcSel;
    portOe        = route.dstEn;
  end
endmodule

// File: rtl/bus_exchanger_datapath.sv
module bus_exchanger_datapath
  import bus_exchanger_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  xferStrobeT                  strobe,
  input  logic [NPORT-1:0][WIDTH-1:0] portIn,
  output logic [NPORT-1:0][WIDTH-1:0] portOut
);
  for (genvar d = 0; d < NPORT; d++) begin : g_dst
    logic [WIDTH-1:0] dataQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ <= '0;
      end else if (strobe.load[d]) begin
        dataQ <= portIn[strobe.srcSel[d]];
      end
    end
    assign portOut[d] = dataQ;
  end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bus_exchanger_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        preset,
  input  logic                        selEn,
  input  logic [SELW-1:0]             selCode,
  input  logic [NPORT-1:0][WIDTH-1:0] portIn,
  output logic [NPORT-1:0][WIDTH-1:0] portOut,
  output logic [NPORT-1:0]            portOe
);
  xferStrobeT strobe;

  bus_exchanger_flow_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .preset  (preset),
    .selEn   (selEn),
    .selCode (selCode),
    .strobe  (strobe),
    .portOe  (portOe)
  );

  bus_exchanger_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .portIn  (portIn),
    .portOut (portOut)
  );
endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk
  import bus_exchanger_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        preset,
  input logic                        selEn,
  input logic [NPORT-1:0][WIDTH-1:0] portOut,
  input logic [NPORT-1:0]            portOe
);
  assert_preset_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    preset |-> (portOe == '0));

  assert_flow_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (selEn && !preset) |=> (preset || portOe == $past(portOe)));

  assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!selEn || preset) |=> $stable(portOut));

  assert_leave_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((portOe != '0) && ($past(portOe) == '0)) |-> $past(!selEn && !preset));

  assert_two_max_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(portOe) <= 2);
endmodule

bind bus_exchanger bus_exchanger_chk #(.WIDTH(WIDTH)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .preset  (preset),
  .selEn   (selEn),
  .portOut (portOut),
  .portOe  (portOe)
);

// File: tb/bus_exchanger_tb_top.sv
module bus_exchanger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 9;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic preset = 1'b0;
  logic selEn = 1'b0;
  logic [4:0] selCode = '0;
  logic [N-1:0][W-1:0] portIn = '0;
  logic [N-1:0][W-1:0] portOut;
  logic [N-1:0] portOe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [N-1:0][W-1:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_exchanger #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .preset(preset), .selEn(selEn),
    .selCode(selCode), .portIn(portIn), .portOut(portOut), .portOe(portOe)
  );

  // expected routing per code: octal digit per destination (3=2B..0=1A), 4+src if active (R5..R8)
  function automatic logic [11:0] expMap(logic [4:0] c);
    case (c)
      5'b01000: return 12'o6005;  5'b01001: return 12'o0005;
      5'b01010: return 12'o0700;  5'b01011: return 12'o0705;
      5'b01100: return 12'o6040;  5'b01101: return 12'o0040;
      5'b01110: return 12'o6000;  5'b01111: return 12'o0740;
      5'b10000: return 12'o0470;  5'b10001: return 12'o0400;
      5'b10010: return 12'o5000;  5'b10011: return 12'o5400;
      5'b10100: return 12'o5006;  5'b10101: return 12'o0006;
      5'b10110: return 12'o0070;  5'b10111: return 12'o0076;
      5'b11000: return 12'o0507;  5'b11001: return 12'o0060;
      5'b11010: return 12'o0007;  5'b11011: return 12'o0067;
      5'b11100: return 12'o4060;  5'b11101: return 12'o4000;
      5'b11110: return 12'o0500;  5'b11111: return 12'o4500;
      default:  return 12'o0000;
    endcase
  endfunction

  function automatic logic [N-1:0] expOe(logic [4:0] c);
    logic [11:0] m = expMap(c);
    logic [N-1:0] e;
    for (int d = 0; d < N; d++) e[d] = m[3*d+2];
    return e;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkOuts(string req);
    for (int d = 0; d < N; d++) chk(req, 64'(portOut[d]), 64'(model[d]));
  endtask

  initial begin
    logic [11:0] m;
    repeat (2) @(negedge clk);
    // R10: reset state
    chk("R10 oe in reset", 64'(portOe), 64'h0);
    chkOuts("R10 data in reset");
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 oe after reset", 64'(portOe), 64'h0);

    // sweep of every code
    for (int c = 0; c < 32; c++) begin
      // select phase (R1), with unrelated input values
      selEn = 1'b0;
      selCode = 5'(c);
      for (int p = 0; p < N; p++) portIn[p] = 9'(c * 13 + p * 71 + 300);
      @(negedge clk);
      chk($sformatf("R6/R7/R8/R5/R9 oe code %0d", c), 64'(portOe), 64'(expOe(5'(c))));
      chkOuts("R1 data held on select edge");
      // data phase (R2, R11)
      selEn = 1'b1;
      selCode = 5'(~c);
      for (int p = 0; p < N; p++) portIn[p] = 9'(c * 37 + p * 101 + 5);
      m = expMap(5'(c));
      for (int d = 0; d < N; d++)
        if (m[3*d+2]) model[d] = portIn[m[3*d +: 2]];
      @(negedge clk);
      chkOuts($sformatf("R2/R11 data code %0d", c));
      chk("R2 flow held on data edge", 64'(portOe), 64'(expOe(5'(c))));
      // R9: inputs change between edges, outputs must not follow
      portIn = ~portIn;
      #1;
      chkOuts("R9 registered outputs");
    end

    // preset behaviour
    selEn = 1'b0;
    selCode = 5'b01111;
    @(negedge clk);
    chk("R6 oe 01111", 64'(portOe), 64'h6);
    #1 preset = 1'b1;
    #1;
    chk("R3 async disable", 64'(portOe), 64'h0);
    @(negedge clk); // select edge while preset high
    chk("R4 preset high blocks select", 64'(portOe), 64'h0);
    preset = 1'b0;
    selEn = 1'b1;
    for (int p = 0; p < N; p++) portIn[p] = 9'(p + 400);
    @(negedge clk); // data edge after preset
    chk("R4 data edge keeps off", 64'(portOe), 64'h0);
    chkOuts("R5 no load after clear");
    selEn = 1'b0;
    @(negedge clk);
    chk("R4 re-enable on select edge", 64'(portOe), 64'h6);

    // reserved code then data edge (R5)
    selCode = 5'b00101;
    @(negedge clk);
    chk("R5 reserved oe", 64'(portOe), 64'h0);
    selEn = 1'b1;
    @(negedge clk);
    chkOuts("R5 reserved no load");

    // reset mid-run (R10)
    rstN = 1'b0;
    #1;
    model = '0;
    chk("R10 async reset oe", 64'(portOe), 64'h0);
    chkOuts("R10 async reset data");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule